// File: doc/BRIEF.md
# Triggered Decimating Capture Buffer

This block records a burst from four parallel 12-bit sample streams: symbol I, symbol Q, oscillator sine and oscillator cosine. A host can then read the burst back at its own pace. The host arms the block. The block then waits for one of four sync sources, picked by a select field. After that sync it counts a programmable number of decimated sample ticks. It then writes 64 consecutive decimated samples of each stream into one bank per stream. When the last entry is written, it raises a done flag and freezes.

Decimation keeps one sample in every one, two, three or four enabled input samples. Only cycles with the sample enable high count as samples. The same decimated tick drives both the start delay and the write pointer. Read-back uses a simple request/acknowledge register port. A fixed address window above 255 maps the four banks in turn, and each 12-bit value reaches the host sign-extended to 16 bits.

Top module: `snap_capture`

## Requirements
- R1: After reset, `done`, `busy` and `host_ack` are 0 and `host_rdata` is 0.
- R2: `trig_sel` picks the start source: 0 = `sync_in`, 1 = `sync_dly_in`, 2 = `sync_tc_in`, 3 = `snap_sync_in`. While the block waits, a pulse on an unselected source starts nothing.
- R3: `rate_sel` = k keeps every (k+1)-th input sample that has `samp_en` high, counted from the cycle after the trigger. Cycles with `samp_en` low are not counted.
- R4: With `start_dly` = D (0 to 255), entry 0 of every bank holds the sample taken on the (D+1)-th decimated tick after the trigger cycle.
- R5: Each bank receives 64 consecutive decimated samples, in entries 0 to 63. `done` rises in the cycle after the 64th write, and `busy` and `done` are never high together.
- R6: From the trigger on, further syncs on any source are ignored. Once `done` is set, it stays set and the stored contents do not change until the next `arm`.
- R7: A capture is only started by `arm`. `arm`, even during a capture, clears `done`, sets `busy` in the following cycle and restarts writing at entry 0.
- R8: A read request (`host_req`=1, `host_we`=0) to address 256+j returns I entry j, 320+j returns Q, 384+j returns sine and 448+j returns cosine. `host_ack` and `host_rdata` are valid in the cycle after the request.
- R9: Read data carries bit 11 of the stored value into bits 15:12.
- R10: A request to an address below 256 gets no acknowledge and returns zero data.
- R11: A write request (`host_we`=1) is never acknowledged and leaves every stored entry unchanged.
- R12: `host_rdata` is zero in every cycle in which `host_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Starts waiting for a trigger and clears done |
| trig_sel | input | 2 | Trigger source select |
| sync_in | input | 1 | Input sync |
| sync_dly_in | input | 1 | Delayed input sync |
| sync_tc_in | input | 1 | Sync counter terminal count |
| snap_sync_in | input | 1 | Dedicated capture sync |
| rate_sel | input | 2 | Decimation: keep one of rate_sel+1 samples |
| start_dly | input | 8 | Decimated ticks to skip after the trigger |
| samp_en | input | 1 | Input sample valid |
| sym_i | input | 12 | Symbol I sample |
| sym_q | input | 12 | Symbol Q sample |
| nco_sin | input | 12 | Oscillator sine sample |
| nco_cos | input | 12 | Oscillator cosine sample |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 9 | Host address |
| host_rdata | output | 16 | Sign-extended read data |
| host_ack | output | 1 | Read acknowledge |
| busy | output | 1 | Armed and not yet done |
| done | output | 1 | Capture complete |

## Verification
Two situations are hard to reach from the ports. The first is the exact edge on which `done` rises after a long delay at the slowest rate, with `samp_en` gaps on top. The second is a stretch in which syncs keep arriving after capture has begun and after it has ended. The bench sweeps every source against every rate, with delays from 0 to 255 and three enable patterns. Every unselected sync toggles the whole time, and the selected one is pulsed at a known edge and then toggled as well. The bench derives from the edge index alone which input edge should land in each entry and when the last write happens. It then checks the completion edge, and reads back all 256 entries only after further syncs, write attempts and idle cycles.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [2:0] {
        SNP_IDLE,
        SNP_WAIT,
        SNP_DELAY,
        SNP_CAPT,
        SNP_DONE
    } snp_state_e;

    localparam int SNP_NSTREAM = 4;
    localparam int SNP_NSRC    = 4;

endpackage

// File: rtl/snap_trig_sel.sv
module snap_trig_sel #(
    parameter int NSRC  = 4,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  src,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NSRC-1:0] hit_vec;

    // one decoded term per source, ORed together
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit_vec[g] = src[g] && (sel == SEL_W'(g));
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
    import snap_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DLY_W  = 8,
    parameter int RATE_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig_hit,
    input  logic              samp_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [DLY_W-1:0]  start_dly,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        snp_state_e          st;
        logic [RATE_W-1:0]   dec;
        logic [DLY_W-1:0]    dly;
        logic [IDX_W-1:0]    ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick;
    logic running;

    always_comb begin
        ctl_d   = ctl_q;
        wr_en   = 1'b0;
        running = (ctl_q.st == SNP_DELAY) || (ctl_q.st == SNP_CAPT);
        tick    = running && samp_en && (ctl_q.dec >= rate_sel);

        if (running && samp_en) begin
            ctl_d.dec = tick ? '0 : ctl_q.dec + 1'b1;
        end

        unique case (ctl_q.st)
            SNP_WAIT: begin
                if (trig_hit) begin
                    ctl_d.st  = SNP_DELAY;
                    ctl_d.dec = '0;
                    ctl_d.dly = start_dly;
                end
            end
            SNP_DELAY: begin
                if (tick) begin
                    if (ctl_q.dly == '0) begin
                        wr_en     = 1'b1;
                        ctl_d.ptr = ctl_q.ptr + 1'b1;
                        ctl_d.st  = SNP_CAPT;
                    end else begin
                        ctl_d.dly = ctl_q.dly - 1'b1;
                    end
                end
            end
            SNP_CAPT: begin
                if (tick) begin
                    wr_en     = 1'b1;
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                    if (ctl_q.ptr == IDX_W'(DEPTH - 1)) begin
                        ctl_d.st = SNP_DONE;
                    end
                end
            end
            default: ;
        endcase

        // arm overrides any state, including a write in the same cycle
        if (arm) begin
            wr_en     = 1'b0;
            ctl_d.st  = SNP_WAIT;
            ctl_d.ptr = '0;
            ctl_d.dec = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: SNP_IDLE, dec: '0, dly: '0, ptr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_idx = ctl_q.ptr;
    assign done   = (ctl_q.st == SNP_DONE);
    assign busy   = (ctl_q.st == SNP_WAIT) || running;

    // R3
    wr_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> samp_en);

    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    // R6
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> (done && $stable(wr_idx)));

    // R7
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (busy && !done && wr_idx == '0));
endmodule

// File: rtl/snap_mem.sv
module snap_mem #(
    parameter int NSTR  = 4,
    parameter int DEPTH = 64,
    parameter int DW    = 12,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int BANK_W = $clog2(NSTR)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [NSTR*DW-1:0]   wr_data,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DW-1:0]        rd_data
);
    logic [DW-1:0] bank_rd [NSTR];

    // one bank per stream, all written by the same strobe
    for (genvar g = 0; g < NSTR; g++) begin : g_bank
        logic [DW-1:0] bank_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                bank_q[wr_idx] <= wr_data[g*DW +: DW];
            end
        end

        assign bank_rd[g] = bank_q[rd_idx];
    end

    assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/snap_host.sv
module snap_host #(
    parameter int ADDR_W = 9,
    parameter int HW     = 16,
    parameter int DW     = 12,
    parameter int IDX_W  = 6,
    parameter int BANK_W = 2,
    localparam int SEL_W = ADDR_W - IDX_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic [IDX_W-1:0]  mem_idx,
    input  logic [DW-1:0]     mem_data,
    output logic [HW-1:0]     rdata,
    output logic              ack
);
    typedef struct packed {
        logic          ack;
        logic [HW-1:0] rdata;
    } hst_t;

    hst_t hst_d, hst_q;
    logic win;
    logic rd_go;

    assign mem_bank = addr[IDX_W+BANK_W-1:IDX_W];
    assign mem_idx  = addr[IDX_W-1:0];

    always_comb begin
        win       = (addr[ADDR_W-1:IDX_W+BANK_W] == SEL_W'(1));
        rd_go     = req && !we && win;
        hst_d.ack = rd_go;
        hst_d.rdata = rd_go ? {{(HW-DW){mem_data[DW-1]}}, mem_data} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_q <= '0;
        end else begin
            hst_q <= hst_d;
        end
    end

    assign ack   = hst_q.ack;
    assign rdata = hst_q.rdata;

    // R10
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req && !we && win));

    // R11
    no_write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> !ack);

    // R9
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($countones(rdata[HW-1:DW-1]) == 0 ||
                 $countones(rdata[HW-1:DW-1]) == HW - DW + 1));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0));
endmodule

// File: rtl/snap_capture.sv
module snap_capture
    import snap_pkg::*;
#(
    parameter int DW     = 12,
    parameter int HW     = 16,
    parameter int DEPTH  = 64,
    parameter int DLY_W  = 8,
    parameter int RATE_W = 2,
    parameter int ADDR_W = 9,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int BANK_W = $clog2(SNP_NSTREAM),
    localparam int TSEL_W = $clog2(SNP_NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [TSEL_W-1:0] trig_sel,
    input  logic              sync_in,
    input  logic              sync_dly_in,
    input  logic              sync_tc_in,
    input  logic              snap_sync_in,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic              samp_en,
    input  logic [DW-1:0]     sym_i,
    input  logic [DW-1:0]     sym_q,
    input  logic [DW-1:0]     nco_sin,
    input  logic [DW-1:0]     nco_cos,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [HW-1:0]     host_rdata,
    output logic              host_ack,
    output logic              busy,
    output logic              done
);
    logic                          trig_hit;
    logic                          wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic [BANK_W-1:0]             rd_bank;
    logic [IDX_W-1:0]              rd_idx;
    logic [DW-1:0]                 rd_data;
    logic [SNP_NSTREAM*DW-1:0]     wr_data;

    // bank order sets the host address map: I, Q, sine, cosine
    assign wr_data = {nco_cos, nco_sin, sym_q, sym_i};

    snap_trig_sel #(.NSRC(SNP_NSRC)) u_trig (
        .src ({snap_sync_in, sync_tc_in, sync_dly_in, sync_in}),
        .sel (trig_sel),
        .hit (trig_hit)
    );

    snap_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W), .RATE_W(RATE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig_hit  (trig_hit),
        .samp_en   (samp_en),
        .rate_sel  (rate_sel),
        .start_dly (start_dly),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .busy      (busy),
        .done      (done)
    );

    snap_mem #(.NSTR(SNP_NSTREAM), .DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    snap_host #(.ADDR_W(ADDR_W), .HW(HW), .DW(DW),
                .IDX_W(IDX_W), .BANK_W(BANK_W)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .we       (host_we),
        .addr     (host_addr),
        .mem_bank (rd_bank),
        .mem_idx  (rd_idx),
        .mem_data (rd_data),
        .rdata    (host_rdata),
        .ack      (host_ack)
    );
endmodule

// File: tb/snap_capture_bench.sv
module snap_capture_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 64;

    logic        clk;
    logic        rst_n;
    logic        arm;
    logic [1:0]  trig_sel;
    logic        sync_in, sync_dly_in, sync_tc_in, snap_sync_in;
    logic [1:0]  rate_sel;
    logic [7:0]  start_dly;
    logic        samp_en;
    logic [11:0] sym_i, sym_q, nco_sin, nco_cos;
    logic        host_req, host_we;
    logic [8:0]  host_addr;
    logic [15:0] host_rdata;
    logic        host_ack;
    logic        busy, done;

    snap_capture u_snap_capture (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_sel(trig_sel),
        .sync_in(sync_in), .sync_dly_in(sync_dly_in), .sync_tc_in(sync_tc_in),
        .snap_sync_in(snap_sync_in), .rate_sel(rate_sel), .start_dly(start_dly),
        .samp_en(samp_en), .sym_i(sym_i), .sym_q(sym_q), .nco_sin(nco_sin),
        .nco_cos(nco_cos), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_rdata(host_rdata), .host_ack(host_ack),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int nx    = 0;
    int c0    = 0;
    int src_v = 0;
    int emode = 0;
    int expn [DEPTH];
    int last_wr;
    bit fin   = 0;
    bit arm_v = 0, req_v = 0, we_v = 0;
    int addr_v = 0;
    logic [15:0] got [4][DEPTH];

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    function automatic logic [11:0] smp(int n, int s);
        return 12'(n * 149 + s * 977 + (n / 8) * 31);
    endfunction

    function automatic bit en_at(int n, int m);
        if (m == 0) return 1'b1;
        if (m == 1) return (n % 3) != 1;
        return ((n % 5) != 0) && ((n % 7) != 3);
    endfunction

    function automatic bit noise(int n, int k);
        return ((n * 7 + k * 3) % 5) == 0;
    endfunction

    function automatic logic [15:0] sx(logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // drive every input for the next rising edge, index nx
    task automatic step();
        logic [3:0] sv;
        @(negedge clk);
        nx++;
        sym_i   = smp(nx, 0);
        sym_q   = smp(nx, 1);
        nco_sin = smp(nx, 2);
        nco_cos = smp(nx, 3);
        samp_en = en_at(nx, emode);
        for (int k = 0; k < 4; k++) begin
            if (k == src_v) sv[k] = (nx == c0) || (nx > c0 && noise(nx, k));
            else            sv[k] = noise(nx, k);
        end
        {snap_sync_in, sync_tc_in, sync_dly_in, sync_in} = sv;
        arm       = arm_v;
        host_req  = req_v;
        host_we   = we_v;
        host_addr = 9'(addr_v);
    endtask

    task automatic hread(input int a, output logic [15:0] d, output logic k);
        req_v = 1; we_v = 0; addr_v = a;
        step();
        req_v = 0;
        step();
        d = host_rdata;
        k = host_ack;
    endtask

    task automatic run_case(input int sc);
        int rate, dly, cnt, t, j, guard;
        logic [15:0] d;
        logic k;
        src_v = sc % 4;
        rate  = (sc / 4) % 4;
        dly   = (sc == 0) ? 0 : (sc == 15) ? 255 : (sc * 37) % 256;
        emode = sc % 3;
        trig_sel  = 2'(src_v);
        rate_sel  = 2'(rate);
        start_dly = 8'(dly);

        if (sc == 5 || sc == 10) begin
            c0 = nx + 5; arm_v = 1; step(); arm_v = 0;
            repeat (20) step();
            chk(busy == 1'b1, "R7 busy before abort", busy, 1);
        end

        c0 = nx + 5;
        arm_v = 1; step(); arm_v = 0;
        step();
        chk(busy == 1'b1, "R7 busy after arm", busy, 1);
        chk(done == 1'b0, "R7 done cleared", done, 0);

        // expected input edge for each entry (R3, R4)
        cnt = 0; j = -1;
        for (int n = c0 + 1; j < DEPTH - 1; n++) begin
            if (en_at(n, emode)) begin
                cnt++;
                if (cnt % (rate + 1) == 0) begin
                    t = cnt / (rate + 1);
                    if (t >= dly + 1) begin
                        j = t - dly - 1;
                        expn[j] = n;
                        last_wr = n;
                    end
                end
            end
        end

        guard = 0;
        while (!done && guard < 6000) begin
            step();
            guard++;
        end
        chk(done == 1'b1, "R5 done reached", done, 1);
        chk(nx - 1 == last_wr, "R5 done edge", nx - 1, last_wr);
        chk(host_ack == 1'b0 && host_rdata == 16'h0, "R12 idle data", host_rdata, 0);

        repeat (25) step();
        chk(done == 1'b1 && busy == 1'b0, "R6 frozen flags", {busy, done}, 1);

        // write attempts into the window
        for (int w = 0; w < 4; w++) begin
            req_v = 1; we_v = 1; addr_v = 256 + ((sc * 13 + w * 67) % 256);
            step();
            req_v = 0; we_v = 0;
            step();
            chk(host_ack == 1'b0, "R11 write no ack", host_ack, 0);
        end

        hread((sc * 15 + 7) % 256, d, k);
        chk(k == 1'b0, "R10 low addr ack", k, 0);
        chk(d == 16'h0, "R10 low addr data", d, 0);

        for (int b = 0; b < 4; b++) begin
            for (int e = 0; e < DEPTH; e++) begin
                hread(256 + b * 64 + e, d, k);
                got[b][e] = d;
                chk(k == 1'b1, "R8 ack", k, 1);
                chk(d == sx(smp(expn[e], b)), "R8 R6 R11 entry", d, sx(smp(expn[e], b)));
            end
        end
        chk(got[src_v][0] == sx(smp(expn[0], src_v)), "R2 R4 first entry",
            got[src_v][0], sx(smp(expn[0], src_v)));
        chk(got[1][1] == sx(smp(expn[1], 1)), "R3 second entry", got[1][1], sx(smp(expn[1], 1)));
        chk(got[3][DEPTH-1] == sx(smp(expn[DEPTH-1], 3)), "R5 last entry",
            got[3][DEPTH-1], sx(smp(expn[DEPTH-1], 3)));
        for (int e = 0; e < DEPTH; e++) begin
            if (got[2][e][11]) begin
                chk(got[2][e][15:12] == 4'hF, "R9 sign fill", got[2][e], sx(got[2][e][11:0]));
                break;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        arm = 0; trig_sel = 0; rate_sel = 0; start_dly = 0; samp_en = 0;
        sync_in = 0; sync_dly_in = 0; sync_tc_in = 0; snap_sync_in = 0;
        sym_i = 0; sym_q = 0; nco_sin = 0; nco_cos = 0;
        host_req = 0; host_we = 0; host_addr = 0;
        repeat (3) step();
        chk(done == 1'b0 && busy == 1'b0, "R1 flags", {busy, done}, 0);
        chk(host_ack == 1'b0 && host_rdata == 16'h0, "R1 host", host_rdata, 0);
        rst_n = 1'b1;
        // R7: syncs on the selected source with no arm start nothing
        src_v = 0; c0 = 0;
        repeat (30) step();
        chk(busy == 1'b0 && done == 1'b0, "R7 no arm", {busy, done}, 0);
        for (int sc = 0; sc < 16; sc++) run_case(sc);
        fin = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog act=%0d exp=%0d", nx, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule